// File: doc/BRIEF.md
# SIMD Unsigned Widening Lane Adder

This execution unit decodes and runs one packed-vector operation. The operation adds each wide unsigned lane of a 128-bit vector to a narrow unsigned lane taken from one 64-bit half of a second vector. The caller supplies a 32-bit instruction word and both 128-bit operands. The unit checks the word against a fixed opcode pattern and extracts the register indices, the lane-size code and the half-select bit. It produces the 128-bit lane-wise sums one clock later.

A narrow lane is zero-extended to twice its width before the addition. Each sum is truncated to the wide lane width, so no carry crosses a lane boundary. The lane-size code is read at run time and picks 8-, 16- or 32-bit narrow lanes. The reserved code is reported as an undefined instruction. A word that fails the pattern is reported on its own flag. The datapath is purely combinational ahead of one register stage, so the latency is the same for every data value.

Top module: `wadd_unit`

## Requirements
- R1: An instruction matches when (instr & 32'hBF20FC00) == 32'h2E201000. An accepted word that does not match raises out_nomatch one cycle later and keeps out_valid and out_undef low.
- R2: For a valid operation, out_dst carries instr[4:0], out_src_wide carries instr[9:5] and out_src_narrow carries instr[20:16].
- R3: Lane-size code instr[23:22]=00 adds eight 8-bit narrow lanes to eight 16-bit wide lanes.
- R4: Code 01 adds four 16-bit narrow lanes to 32-bit wide lanes. Code 10 adds two 32-bit narrow lanes to 64-bit wide lanes.
- R5: A matching word with code 11 raises out_undef one cycle later, and out_valid and out_nomatch stay low.
- R6: instr[30]=0 takes the narrow lanes from op_narrow[63:0]. instr[30]=1 takes them from op_narrow[127:64]. Narrow lane e sits at bits [e*n +: n] of that half, and wide lane e sits at bits [e*2n +: 2n].
- R7: The narrow lane is zero-extended before the addition. Each lane sum is truncated to 2n bits, and its carry does not reach the next lane.
- R8: Exactly one of out_valid, out_undef and out_nomatch is high in the cycle after each cycle in which in_valid is high. All three are low in the cycle after a cycle in which in_valid is low.
- R9: out_result, out_dst, out_src_wide and out_src_narrow change only in the cycle after a valid operation. Otherwise they hold their values.
- R10: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| op_wide | input | 128 | Vector of wide lanes |
| op_narrow | input | 128 | Vector holding both narrow halves |
| out_valid | output | 1 | Result of a valid operation is present |
| out_undef | output | 1 | Matching word with the reserved lane size |
| out_nomatch | output | 1 | Word did not match the opcode pattern |
| out_result | output | 128 | Lane-wise sums |
| out_dst | output | 5 | Destination register index |
| out_src_wide | output | 5 | Index of the wide-lane source |
| out_src_narrow | output | 5 | Index of the narrow-lane source |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, 64-bit narrow halves, an 8-bit minimum narrow lane and three lane sizes. With these values every generated lane variant is reachable from the lane-size code, up to the 64-bit wide lanes. All-ones operands in every size and half drive a carry out of every lane, so a carry that leaks between lanes shows up in the result. Directed words for the reserved size code and near-miss opcodes are mixed with idle cycles and back-to-back random operations. These cover the flag exclusivity and the register hold behaviour.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam logic [INSTR_W-1:0] MATCH_MASK  = 32'hBF20_FC00;
  localparam logic [INSTR_W-1:0] MATCH_VALUE = 32'h2E20_1000;

  typedef enum logic [1:0] {
    LSZ_BYTE = 2'd0,
    LSZ_HALF = 2'd1,
    LSZ_WORD = 2'd2,
    LSZ_RSVD = 2'd3
  } lane_size_e;

  typedef struct packed {
    logic                 match;
    logic                 upper;
    lane_size_e           lsize;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src_w;
    logic [REG_IDX_W-1:0] src_n;
  } dec_t;
endpackage

// File: rtl/wadd_decode.sv
module wadd_decode
  import wadd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic               op_ok
);
  always_comb begin
    dec.match = ((instr & MATCH_MASK) == MATCH_VALUE);
    dec.upper = instr[30];
    dec.lsize = lane_size_e'(instr[23:22]);
    dec.src_n = instr[20:16];
    dec.src_w = instr[9:5];
    dec.dst   = instr[4:0];
    op_ok     = dec.match && (dec.lsize != LSZ_RSVD);
  end
endmodule

// File: rtl/wadd_half_sel.sv
module wadd_half_sel #(
  parameter int VEC_W = 128,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic              upper,
  output logic [HALF_W-1:0] half
);
  always_comb half = upper ? vec[VEC_W-1:HALF_W] : vec[HALF_W-1:0];
endmodule

// File: rtl/wadd_lane_array.sv
module wadd_lane_array #(
  parameter int VEC_W      = 128,
  parameter int MIN_NARROW = 8,
  parameter int NUM_SIZES  = 3,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic [VEC_W-1:0]  wide,
  input  logic [HALF_W-1:0] narrow,
  input  logic [1:0]        size_code,
  output logic [VEC_W-1:0]  sum
);
  logic [NUM_SIZES-1:0][VEC_W-1:0] sum_by_size;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int NW = MIN_NARROW << s;
    localparam int WW = 2 * NW;
    localparam int NL = HALF_W / NW;
    for (genvar e = 0; e < NL; e++) begin : g_lane
      logic [WW-1:0] ext_n;
      assign ext_n = {{NW{1'b0}}, narrow[e*NW +: NW]};
      assign sum_by_size[s][e*WW +: WW] = wide[e*WW +: WW] + ext_n;
    end
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (int'(size_code) == s) sum = sum_by_size[s];
    end
  end
endmodule

// File: rtl/wadd_unit.sv
module wadd_unit
  import wadd_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int MIN_NARROW = 8,
  parameter int NUM_SIZES  = 3,
  localparam int HALF_W = VEC_W / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [VEC_W-1:0]     op_wide,
  input  logic [VEC_W-1:0]     op_narrow,
  output logic                 out_valid,
  output logic                 out_undef,
  output logic                 out_nomatch,
  output logic [VEC_W-1:0]     out_result,
  output logic [REG_IDX_W-1:0] out_dst,
  output logic [REG_IDX_W-1:0] out_src_wide,
  output logic [REG_IDX_W-1:0] out_src_narrow
);
  dec_t              dec;
  logic              op_ok;
  logic [HALF_W-1:0] narrow_half;
  logic [VEC_W-1:0]  lane_sum;

  wadd_decode i_dec (.instr(instr), .dec(dec), .op_ok(op_ok));

  wadd_half_sel #(.VEC_W(VEC_W)) i_half (
    .vec(op_narrow), .upper(dec.upper), .half(narrow_half)
  );

  wadd_lane_array #(.VEC_W(VEC_W), .MIN_NARROW(MIN_NARROW), .NUM_SIZES(NUM_SIZES)) i_lanes (
    .wide(op_wide), .narrow(narrow_half), .size_code(dec.lsize), .sum(lane_sum)
  );

  // next-state logic
  logic                 valid_d, undef_d, nomatch_d, load_en;
  logic [VEC_W-1:0]     result_d;
  logic [REG_IDX_W-1:0] dst_d, srcw_d, srcn_d;

  always_comb begin
    valid_d   = in_valid && op_ok;
    undef_d   = in_valid && dec.match && !op_ok;
    nomatch_d = in_valid && !dec.match;
    load_en   = valid_d;
    result_d  = load_en ? lane_sum  : out_result;
    dst_d     = load_en ? dec.dst   : out_dst;
    srcw_d    = load_en ? dec.src_w : out_src_wide;
    srcn_d    = load_en ? dec.src_n : out_src_narrow;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_undef      <= 1'b0;
      out_nomatch    <= 1'b0;
      out_result     <= '0;
      out_dst        <= '0;
      out_src_wide   <= '0;
      out_src_narrow <= '0;
    end else begin
      out_valid      <= valid_d;
      out_undef      <= undef_d;
      out_nomatch    <= nomatch_d;
      out_result     <= result_d;
      out_dst        <= dst_d;
      out_src_wide   <= srcw_d;
      out_src_narrow <= srcn_d;
    end
  end

  // R8: at most one outcome flag at a time
  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_undef, out_nomatch}));

  // R8: an idle input cycle leaves all flags low
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(out_valid || out_undef || out_nomatch));

  // R1: a word outside the pattern never yields a result
  a_r1_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec.match) |=> (out_nomatch && !out_valid));

  // R5: reserved lane size is undefined, never valid
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.match && dec.lsize == LSZ_RSVD) |=> (out_undef && !out_valid));

  // R9: payload holds without a valid operation
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && op_ok) |=> ($stable(out_result) && $stable(out_dst)));
endmodule

// File: tb/test_wadd_unit.sv
module test_wadd_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] op_wide, op_narrow;
  logic         out_valid, out_undef, out_nomatch;
  logic [127:0] out_result;
  logic [4:0]   out_dst, out_src_wide, out_src_narrow;

  wadd_unit i_wadd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .op_wide(op_wide), .op_narrow(op_narrow),
    .out_valid(out_valid), .out_undef(out_undef), .out_nomatch(out_nomatch),
    .out_result(out_result), .out_dst(out_dst),
    .out_src_wide(out_src_wide), .out_src_narrow(out_src_narrow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  logic         e_valid, e_undef, e_nomatch;
  logic [127:0] e_result;
  logic [4:0]   e_dst, e_sw, e_sn;
  string        e_tag;

  function automatic logic [127:0] ref_sum(logic [127:0] a, logic [127:0] b,
                                           int sz, bit hi);
    logic [127:0] r = '0;
    int n = 8 << sz;
    logic [127:0] mn = (128'(1) << n) - 1;
    logic [127:0] mw = (128'(1) << (2*n)) - 1;
    for (int e = 0; e < 64 / n; e++) begin
      logic [127:0] wl = (a >> (e*2*n)) & mw;
      logic [127:0] nl = (b >> ((hi ? 64 : 0) + e*n)) & mn;
      r = r | (((wl + nl) & mw) << (e*2*n));
    end
    return r;
  endfunction

  task automatic cmp1(string tag, string fld, logic [127:0] act, logic [127:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    cmp1(e_tag, "out_valid",   128'(out_valid),   128'(e_valid));
    cmp1(e_tag, "out_undef",   128'(out_undef),   128'(e_undef));
    cmp1(e_tag, "out_nomatch", 128'(out_nomatch), 128'(e_nomatch));
    cmp1(e_tag, "out_result",  out_result,        e_result);
    cmp1(e_tag, "out_dst",     128'(out_dst),     128'(e_dst));
    cmp1(e_tag, "out_src_wide",   128'(out_src_wide), 128'(e_sw));
    cmp1(e_tag, "out_src_narrow", 128'(out_src_narrow), 128'(e_sn));
  endtask

  // check outputs from the previous step, then drive the next one
  task automatic step(string tag, bit v, logic [31:0] w, logic [127:0] a, logic [127:0] b);
    bit m, ok;
    @(negedge clk);
    compare();
    in_valid = v; instr = w; op_wide = a; op_narrow = b;
    m  = ((w & 32'hBF20FC00) == 32'h2E201000);
    ok = m && (w[23:22] != 2'b11);
    e_tag     = tag;
    e_valid   = v && ok;
    e_undef   = v && m && !ok;
    e_nomatch = v && !m;
    if (v && ok) begin
      e_result = ref_sum(a, b, int'(w[23:22]), w[30]);
      e_dst = w[4:0]; e_sw = w[9:5]; e_sn = w[20:16];
    end
  endtask

  function automatic logic [31:0] mk(bit q, logic [1:0] sz, logic [4:0] rm,
                                     logic [4:0] rn, logic [4:0] rd);
    return 32'h2E201000 | (32'(q) << 30) | (32'(sz) << 22) | (32'(rm) << 16)
           | (32'(rn) << 5) | 32'(rd);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; instr = '0; op_wide = '0; op_narrow = '0;
    e_valid = 0; e_undef = 0; e_nomatch = 0; e_result = '0;
    e_dst = '0; e_sw = '0; e_sn = '0; e_tag = "R10";
    repeat (3) @(negedge clk);
    compare(); // R10 reset state
    rst_n = 1'b1;

    // R3 and R6: byte lanes, both halves
    step("R3", 1, mk(0, 2'd0, 5'd1, 5'd2, 5'd3),
         128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F, 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100);
    step("R6", 1, mk(1, 2'd0, 5'd4, 5'd5, 5'd6),
         128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h0102_0304_0506_0708_F0F1_F2F3_F4F5_F6F7);
    // R4: half-word and word lanes
    step("R4", 1, mk(0, 2'd1, 5'd7, 5'd8, 5'd9), rnd128(), rnd128());
    step("R4", 1, mk(1, 2'd1, 5'd10, 5'd11, 5'd12), rnd128(), rnd128());
    step("R4", 1, mk(0, 2'd2, 5'd13, 5'd14, 5'd15), rnd128(), rnd128());
    step("R6", 1, mk(1, 2'd2, 5'd16, 5'd17, 5'd18), rnd128(), rnd128());
    // R7: carry out of every lane must be dropped
    for (int s = 0; s < 3; s++)
      for (int q = 0; q < 2; q++)
        step("R7", 1, mk(q[0], s[1:0], 5'd19, 5'd20, 5'd21), '1, '1);
    step("R7", 1, mk(0, 2'd0, 5'd0, 5'd0, 5'd0), {8{16'hFFFF}}, 128'h01);
    // R8: idle cycle
    step("R8", 0, mk(0, 2'd0, 5'd1, 5'd1, 5'd1), rnd128(), rnd128());
    // R5: reserved size, R9 hold afterwards
    step("R5", 1, mk(0, 2'd3, 5'd22, 5'd23, 5'd24), rnd128(), rnd128());
    step("R5", 1, mk(1, 2'd3, 5'd25, 5'd26, 5'd27), rnd128(), rnd128());
    // R1: near-miss words (one fixed bit flipped each)
    step("R1", 1, mk(0, 2'd0, 5'd1, 5'd2, 5'd3) ^ 32'h8000_0000, rnd128(), rnd128());
    step("R1", 1, mk(0, 2'd1, 5'd1, 5'd2, 5'd3) ^ 32'h0000_2000, rnd128(), rnd128());
    step("R1", 1, mk(0, 2'd2, 5'd1, 5'd2, 5'd3) ^ 32'h0020_0000, rnd128(), rnd128());
    step("R9", 0, '0, rnd128(), rnd128());
    // R2: field extraction with extreme indices
    step("R2", 1, mk(1, 2'd1, 5'd31, 5'd0, 5'd31), rnd128(), rnd128());
    step("R2", 1, mk(0, 2'd2, 5'd0, 5'd31, 5'd0), rnd128(), rnd128());
    // mixed random traffic
    for (int i = 0; i < 200; i++) begin
      logic [31:0] w = mk($urandom_range(1, 0) == 1, 2'($urandom_range(3, 0)),
                          5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom_range(7, 0) == 0) w = w ^ (32'h1 << 10);
      step("R8", $urandom_range(3, 0) != 0, w, rnd128(), rnd128());
    end
    step("R8", 0, '0, '0, '0);
    step("R8", 0, '0, '0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule